// File: doc/BRIEF.md
# Dual-Port Contention Busy Arbiter

This block sits beside a two-port memory and settles who owns a word when both ports reach for it at once. Each port, left and right, brings an enable, a write request and an address. When both ports are enabled on the same address, the block gives the word to the port that set up the shared access first. It then pulls an active-low busy flag toward the other port and suppresses that port's write strobe toward the array.

A mode input chooses the busy direction. When the mode input is high the block is the master: it keeps the ownership state and drives its busy flags out, so that companion devices widening the word can follow the same decision. When the mode input is low the block is a slave: its own busy outputs stay inactive, and it gates each port's write with a busy flag that an external master supplies. Decisions are registered, and the block runs on one clock.

Top module: `dp_busy_arbiter`

## Requirements
- R1: After reset, both busy outputs are high (inactive) and no port owns the location, so the first match is decided as a fresh contest.
- R2: A busy output can go low only when, on the previous clock edge, both enables were high with equal addresses and the mode input was high. Different addresses or a low enable leave both busy outputs high.
- R3: When one port was already enabled on an address in the previous cycle, and the other port now creates the match by moving its address or raising its enable, the port already present owns the location. Busy goes low toward the newcomer.
- R4: The owner keeps the location for as long as the match lasts, whatever either port does to its write request.
- R5: After a clock edge that samples no match, because the addresses differ or an enable is low, both busy outputs are high again.
- R6: When both ports create the match in the same cycle, the left port wins and only the right busy goes low. The two busy outputs are never low together.
- R7: With the mode input low (slave), both busy outputs are held high whatever the ports do.
- R8: In master mode, a port's gated write equals enable AND write request while that port's busy output is high, and it is forced low while that busy output is low.
- R9: In slave mode, a port's gated write equals enable AND write request AND its busy input (active low, so low blocks the write). In master mode the busy inputs have no effect.
- R10: Busy reacts one clock after the match is sampled. In the cycle in which a match is first presented, both busy outputs are still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = master (computes and drives busy), 0 = slave (uses busy inputs) |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write request |
| l_addr | input | AW | Left port address |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write request |
| r_addr | input | AW | Right port address |
| busy_l_in_n | input | 1 | External busy toward left, active low, used in slave mode |
| busy_r_in_n | input | 1 | External busy toward right, active low, used in slave mode |
| busy_l_out_n | output | 1 | Busy toward left, active low, driven in master mode |
| busy_r_out_n | output | 1 | Busy toward right, active low, driven in master mode |
| l_wr_gated | output | 1 | Left write strobe to the array after busy gating |
| r_wr_gated | output | 1 | Right write strobe to the array after busy gating |

## Verification
Two kinds of collision can fall into the same cycle: both ports arriving on the same address together, and one port's arrival coinciding with the other's write request. The bench provokes the first by raising both enables on one address from an idle state. It provokes the second by moving a port onto an occupied address while the opposite port writes. It judges the winner, the single low busy flag and the gated strobes against a behavioural model that tracks each port's previous enable and address. It also sets the cycle of the first visible busy against the cycle in which the match was presented.

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic          busy_l_in_n,
  input  logic          busy_r_in_n,
  output logic          busy_l_out_n,
  output logic          busy_r_out_n,
  output logic          l_wr_gated,
  output logic          r_wr_gated
);

  typedef enum logic [1:0] {OWN_NONE, OWN_LEFT, OWN_RIGHT} own_t;

  own_t          owner_q, owner_d;
  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          pair_match, l_held, r_held;
  logic          l_busy_n, r_busy_n;

  assign pair_match = l_en & r_en & (l_addr == r_addr);
  assign l_held     = l_en & l_en_q & (l_addr == l_addr_q);
  assign r_held     = r_en & r_en_q & (r_addr == r_addr_q);

  always_comb begin
    owner_d = owner_q;
    if (!master_mode || !pair_match)
      owner_d = OWN_NONE;
    else if (owner_q == OWN_NONE)
      owner_d = (r_held && !l_held) ? OWN_RIGHT : OWN_LEFT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      owner_q  <= owner_d;
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  assign busy_l_out_n = ~(master_mode & (owner_q == OWN_RIGHT));
  assign busy_r_out_n = ~(master_mode & (owner_q == OWN_LEFT));

  assign l_busy_n = master_mode ? busy_l_out_n : busy_l_in_n;
  assign r_busy_n = master_mode ? busy_r_out_n : busy_r_in_n;

  assign l_wr_gated = l_en & l_wr & l_busy_n;
  assign r_wr_gated = r_en & r_wr & r_busy_n;

  // R2
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_l_out_n || !busy_r_out_n) |-> ($past(pair_match) && master_mode));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_match |=> (busy_l_out_n && busy_r_out_n));

  // R3
  first_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && pair_match && l_held && !r_held && owner_q == OWN_NONE)
      |=> (!master_mode || (!busy_r_out_n && busy_l_out_n)));

  // R6
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && pair_match && !l_held && !r_held && owner_q == OWN_NONE)
      |=> (!master_mode || (!busy_r_out_n && busy_l_out_n)));

  // R8
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !busy_r_out_n) |-> !r_wr_gated);

  // R9
  slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !busy_l_in_n) |-> !l_wr_gated);

endmodule

// File: tb/dp_busy_arbiter_bench.sv
module dp_busy_arbiter_bench;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic busy_l_in_n = 1'b1, busy_r_in_n = 1'b1;
  logic busy_l_out_n, busy_r_out_n, l_wr_gated, r_wr_gated;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int own_m = 0;
  bit plen = 0, pren = 0;
  logic [AW-1:0] pla = '0, pra = '0;

  always #4 clk = ~clk;

  dp_busy_arbiter #(.AW(AW)) u_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .busy_l_in_n(busy_l_in_n), .busy_r_in_n(busy_r_in_n),
    .busy_l_out_n(busy_l_out_n), .busy_r_out_n(busy_r_out_n),
    .l_wr_gated(l_wr_gated), .r_wr_gated(r_wr_gated)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic model_cmp(input string tag);
    logic ebl, ebr, lb, rb;
    ebl = !(master_mode && own_m == 2);
    ebr = !(master_mode && own_m == 1);
    lb  = master_mode ? ebl : busy_l_in_n;
    rb  = master_mode ? ebr : busy_r_in_n;
    chk(tag, "busy_l_out_n", busy_l_out_n, ebl);
    chk(tag, "busy_r_out_n", busy_r_out_n, ebr);
    chk(tag, "l_wr_gated", l_wr_gated, l_en && l_wr && lb);
    chk(tag, "r_wr_gated", r_wr_gated, r_en && r_wr && rb);
  endtask

  task automatic tick(input string tag);
    bit m, lh, rh;
    #1 model_cmp(tag);
    @(posedge clk);
    m  = l_en && r_en && (l_addr == r_addr);
    lh = l_en && plen && (l_addr == pla);
    rh = r_en && pren && (r_addr == pra);
    if (!master_mode || !m) own_m = 0;
    else if (own_m == 0) own_m = (rh && !lh) ? 2 : 1;
    plen = l_en; pren = r_en; pla = l_addr; pra = r_addr;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1", "busy_l_out_n in reset", busy_l_out_n, 1'b1);
    chk("R1", "busy_r_out_n in reset", busy_r_out_n, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 different addresses, no busy
    l_en = 1; r_en = 1; l_addr = 15'd3; r_addr = 15'd4; l_wr = 1; r_wr = 1;
    tick("R2"); tick("R2");
    chk("R2", "busy_l_out_n no match", busy_l_out_n, 1'b1);
    chk("R2", "busy_r_out_n no match", busy_r_out_n, 1'b1);
    chk("R8", "l_wr_gated free", l_wr_gated, 1'b1);

    // R3 left present, right arrives
    r_addr = 15'd3;
    #1 chk("R10", "busy_r_out_n same cycle as match", busy_r_out_n, 1'b1);
    tick("R3");
    chk("R3", "busy_r_out_n newcomer right", busy_r_out_n, 1'b0);
    chk("R3", "busy_l_out_n owner left", busy_l_out_n, 1'b1);
    chk("R8", "r_wr_gated blocked", r_wr_gated, 1'b0);
    chk("R8", "l_wr_gated passes", l_wr_gated, 1'b1);
    // R4 persistence, toggling writes
    l_wr = 0; tick("R4"); r_wr = 0; tick("R4"); r_wr = 1; tick("R4");
    chk("R4", "busy_r_out_n held", busy_r_out_n, 1'b0);
    // R5 release by address
    r_addr = 15'd7; tick("R5");
    chk("R5", "busy_r_out_n released", busy_r_out_n, 1'b1);
    chk("R5", "r_wr_gated restored", r_wr_gated, 1'b1);

    // R3 right present, left arrives
    r_addr = 15'd9; tick("R3");
    l_addr = 15'd9; l_wr = 1; tick("R3");
    chk("R3", "busy_l_out_n newcomer left", busy_l_out_n, 1'b0);
    chk("R3", "busy_r_out_n owner right", busy_r_out_n, 1'b1);
    chk("R8", "l_wr_gated blocked", l_wr_gated, 1'b0);
    // R5 release by enable
    r_en = 0; tick("R5");
    chk("R5", "busy_l_out_n released by enable", busy_l_out_n, 1'b1);

    // R6 tie from idle
    l_en = 0; tick("R6");
    l_en = 1; r_en = 1; l_addr = 15'h7FFF; r_addr = 15'h7FFF; tick("R6");
    chk("R6", "busy_r_out_n tie loser", busy_r_out_n, 1'b0);
    chk("R6", "busy_l_out_n tie winner", busy_l_out_n, 1'b1);
    // R6 tie by both addresses moving
    l_addr = 15'd20; tick("R6");
    l_addr = 15'd21; r_addr = 15'd21; tick("R6");
    chk("R6", "busy_r_out_n address tie", busy_r_out_n, 1'b0);
    chk("R6", "busy_l_out_n address tie", busy_l_out_n, 1'b1);

    // R9 busy inputs ignored in master mode
    l_addr = 15'd1; r_addr = 15'd2; busy_l_in_n = 0; busy_r_in_n = 0;
    tick("R9");
    chk("R9", "l_wr_gated master ignores input", l_wr_gated, 1'b1);

    // R7 slave mode: outputs quiet, writes follow inputs
    master_mode = 0; l_addr = 15'd5; r_addr = 15'd5; busy_l_in_n = 0; busy_r_in_n = 1;
    tick("R7"); tick("R7");
    chk("R7", "busy_l_out_n slave", busy_l_out_n, 1'b1);
    chk("R7", "busy_r_out_n slave", busy_r_out_n, 1'b1);
    chk("R9", "l_wr_gated slave blocked", l_wr_gated, 1'b0);
    chk("R9", "r_wr_gated slave passes", r_wr_gated, 1'b1);
    busy_l_in_n = 1; busy_r_in_n = 0; #1;
    chk("R9", "l_wr_gated slave passes", l_wr_gated, 1'b1);
    chk("R9", "r_wr_gated slave blocked", r_wr_gated, 1'b0);
    tick("R9");

    // back to master with a standing match: treated as fresh tie
    master_mode = 1; busy_r_in_n = 1; tick("R1");
    chk("R6", "busy_r_out_n after mode switch", busy_r_out_n, 1'b0);

    // sweep of patterns compared against model
    for (int i = 0; i < 200; i++) begin
      l_en = (i % 7) != 0; r_en = (i % 5) != 1;
      l_wr = i[0]; r_wr = i[1];
      l_addr = 15'((i / 3) % 4); r_addr = 15'((i / 4) % 4);
      master_mode = (i % 37) < 33;
      busy_l_in_n = i[2]; busy_r_in_n = i[3];
      tick("R4");
      chk("R6", "never both busy", !busy_l_out_n && !busy_r_out_n, 1'b0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule